// File: doc/BRIEF.md
# Configurable-format UART transmitter

This block turns characters into frames on an asynchronous serial line. A character arrives on a valid/ready handshake together with its format: how many data bits, which parity rule, and how long the stop period lasts. Once accepted, the block drives a low start bit. It then sends the data bits least significant first, an optional parity bit and a high stop period. After that the line returns to its high idle level and the block can take the next character.

Bit timing comes from a tick at 16 times the bit rate. A programmable divider makes this tick from the block clock, and an optional fixed divide-by-8 prescaler can sit in front of the divider. Every bit lasts 16 ticks. The stop period lasts 16, 24 or 32 ticks, so the one-and-a-half stop length is exact to the tick. The format, the divisor and the prescale choice are all captured when a character is accepted. They are held until the frame ends, so the format inputs may change freely while a frame is on the line.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, tx_line is high and in_ready is high.
- R2: in_ready is high only while no frame is in progress. A character is taken on a clock edge where in_valid and in_ready are both high. in_ready goes low from that edge until the edge that ends the last stop tick.
- R3: A frame begins with a low start bit on the edge that takes the character. The start bit and every data or parity bit last exactly 16 ticks.
- R4: cfg_len selects the number of data bits: 2'b11 sends 6, 2'b10 sends 7, and 2'b00 or 2'b01 sends 8. The bits are sent least significant first. Input bits above the selected length have no effect on the line.
- R5: cfg_par 3'b000 appends a bit that makes the count of ones over the sent data bits plus the parity bit even. 3'b001 appends a bit that makes that count odd.
- R6: cfg_par 3'b010 appends a constant 0 and 3'b011 appends a constant 1. Any cfg_par with bit 2 set sends no parity bit.
- R7: cfg_stop selects the length of the high stop period: 2'b00 gives 16 ticks, 2'b01 gives 24 ticks and 2'b10 gives 32 ticks. The reserved code 2'b11 gives 16 ticks.
- R8: One tick spans (baud_div+1) clocks, or 8*(baud_div+1) clocks when cfg_pre8 is 1. Tick phase restarts when a character is taken, so a frame of N ticks keeps in_ready low for exactly N times the tick span in clocks.
- R9: All format inputs, baud_div and cfg_pre8 are sampled only when a character is taken. Changing them during a frame does not alter that frame.
- R10: Between frames tx_line stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Block idle, character will be taken |
| in_data | input | 8 | Character, bit 0 sent first |
| cfg_len | input | 2 | Data length code |
| cfg_par | input | 3 | Parity rule code |
| cfg_stop | input | 2 | Stop length code |
| cfg_pre8 | input | 1 | Insert divide-by-8 prescaler |
| baud_div | input | DIV_W | Tick divisor minus one |
| tx_line | output | 1 | Serial output, idle high |

## Verification
A wrong bit counter, tick counter or captured format shows up on tx_line as a level that differs from the reference model. It appears on the first clock edge where the wrong bit or the shifted bit boundary begins, which is at most one bit period after the fault. A tick generator with the wrong phase or span shifts every later boundary, so the next edge of the start bit exposes it. The length of the busy interval on in_ready adds a second view of the tick span.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } tx_state_e;

   typedef struct packed {
      logic [1:0] len;
      logic [2:0] par;
      logic [1:0] stop;
   } tx_fmt_t;

   // index of the final data bit for a length code
   function automatic logic [2:0] last_data_idx(input logic [1:0] len);
      case (len)
         2'b11:   return 3'd5;
         2'b10:   return 3'd6;
         default: return 3'd7;
      endcase
   endfunction

   // mask of the data bits that take part in a frame
   function automatic logic [7:0] data_mask(input logic [1:0] len);
      case (len)
         2'b11:   return 8'h3F;
         2'b10:   return 8'h7F;
         default: return 8'hFF;
      endcase
   endfunction

endpackage

// File: rtl/uart_tx_tick.sv
module uart_tx_tick #(
   parameter int unsigned PRE_DIV = 8,
   parameter int unsigned DIV_W   = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic             pre_en,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   localparam int unsigned PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

   logic             src_en;
   logic [DIV_W-1:0] dcnt;

   generate
      if (PRE_DIV > 1) begin : g_pre
         logic [PW-1:0] pcnt;

         always_ff @(posedge clk) begin
            if (!rst_n || clr) pcnt <= '0;
            else if (run)      pcnt <= pcnt + 1'b1;
         end

         assign src_en = !pre_en || (pcnt == PW'(PRE_DIV - 1));

         // with the prescaler in use, ticks are never back to back
         p_tick_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (run && pre_en && tick) |=> !tick);
      end else begin : g_nopre
         logic unused_pre;
         assign unused_pre = pre_en;
         assign src_en     = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || clr)       dcnt <= '0;
      else if (run && src_en)  dcnt <= (dcnt == div) ? '0 : dcnt + 1'b1;
   end

   assign tick = run && src_en && (dcnt == div);

endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity
   import uart_tx_pkg::*;
(
   input  logic [7:0] data,
   input  logic [1:0] len,
   input  logic [2:0] mode,
   output logic       par_bit,
   output logic       par_on
);

   logic ones_odd;

   assign ones_odd = ^(data & data_mask(len));

   always_comb begin
      par_on  = 1'b1;
      par_bit = 1'b0;
      case (mode)
         3'b000:  par_bit = ones_odd;
         3'b001:  par_bit = ~ones_odd;
         3'b010:  par_bit = 1'b0;
         3'b011:  par_bit = 1'b1;
         default: par_on  = 1'b0;
      endcase
   end

endmodule

// File: rtl/uart_tx_seq.sv
module uart_tx_seq
   import uart_tx_pkg::*;
#(
   parameter int unsigned OVERSAMPLE = 16,
   parameter int unsigned DIV_W      = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             in_valid,
   input  logic [7:0]       in_data,
   input  logic [1:0]       cfg_len,
   input  logic [2:0]       cfg_par,
   input  logic [1:0]       cfg_stop,
   input  logic             cfg_pre8,
   input  logic [DIV_W-1:0] baud_div,
   input  logic             par_bit,
   input  logic             par_on,
   output logic             in_ready,
   output logic             tx_line,
   output logic             run,
   output logic             clr,
   output logic             pre_q,
   output logic [DIV_W-1:0] div_q,
   output logic [7:0]       data_q,
   output tx_fmt_t          fmt_q
);

   localparam int unsigned TW = $clog2(2 * OVERSAMPLE);
   localparam logic [TW-1:0] BIT_LAST  = TW'(OVERSAMPLE - 1);
   localparam logic [TW-1:0] STOP_1    = TW'(OVERSAMPLE - 1);
   localparam logic [TW-1:0] STOP_1P5  = TW'(OVERSAMPLE + OVERSAMPLE / 2 - 1);
   localparam logic [TW-1:0] STOP_2    = TW'(2 * OVERSAMPLE - 1);

   tx_state_e     st_q;
   logic [TW-1:0] tcnt;
   logic [2:0]    bidx;
   logic [7:0]    shift_q;
   logic          line_q;
   logic [TW-1:0] stop_last;
   logic          bit_end;

   assign in_ready = (st_q == ST_IDLE);
   assign clr      = in_valid && in_ready;
   assign run      = !in_ready;
   assign tx_line  = line_q;

   always_comb begin
      case (fmt_q.stop)
         2'b01:   stop_last = STOP_1P5;
         2'b10:   stop_last = STOP_2;
         default: stop_last = STOP_1;
      endcase
      bit_end = tick && (tcnt == ((st_q == ST_STOP) ? stop_last : BIT_LAST));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         line_q  <= 1'b1;
         tcnt    <= '0;
         bidx    <= '0;
         shift_q <= '0;
         data_q  <= '0;
         fmt_q   <= '0;
         pre_q   <= 1'b0;
         div_q   <= '0;
      end else if (st_q == ST_IDLE) begin
         if (in_valid) begin
            st_q   <= ST_START;
            line_q <= 1'b0;
            tcnt   <= '0;
            data_q <= in_data;
            fmt_q  <= '{len: cfg_len, par: cfg_par, stop: cfg_stop};
            pre_q  <= cfg_pre8;
            div_q  <= baud_div;
         end
      end else if (tick) begin
         tcnt <= bit_end ? '0 : tcnt + 1'b1;
         if (bit_end) begin
            case (st_q)
               ST_START: begin
                  st_q    <= ST_DATA;
                  line_q  <= data_q[0];
                  shift_q <= data_q >> 1;
                  bidx    <= '0;
               end
               ST_DATA: begin
                  if (bidx == last_data_idx(fmt_q.len)) begin
                     st_q   <= par_on ? ST_PAR : ST_STOP;
                     line_q <= par_on ? par_bit : 1'b1;
                  end else begin
                     line_q  <= shift_q[0];
                     shift_q <= shift_q >> 1;
                     bidx    <= bidx + 1'b1;
                  end
               end
               ST_PAR: begin
                  st_q   <= ST_STOP;
                  line_q <= 1'b1;
               end
               default: begin
                  st_q   <= ST_IDLE;
                  line_q <= 1'b1;
               end
            endcase
         end
      end
   end

   p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);

   p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !tx_line);

   p_stop_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_STOP) |-> tx_line);

   p_fmt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_IDLE) |=> (st_q == ST_IDLE) || ($stable(fmt_q) && $stable(div_q)));

   p_idle_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> tx_line);

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
   import uart_tx_pkg::*;
#(
   parameter int unsigned OVERSAMPLE = 16,
   parameter int unsigned PRE_DIV    = 8,
   parameter int unsigned DIV_W      = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [7:0]       in_data,
   input  logic [1:0]       cfg_len,
   input  logic [2:0]       cfg_par,
   input  logic [1:0]       cfg_stop,
   input  logic             cfg_pre8,
   input  logic [DIV_W-1:0] baud_div,
   output logic             tx_line
);

   initial begin
      assert (OVERSAMPLE >= 4 && (OVERSAMPLE % 2) == 0)
         else $error("OVERSAMPLE must be even and at least 4");
      assert (PRE_DIV >= 1 && (PRE_DIV & (PRE_DIV - 1)) == 0)
         else $error("PRE_DIV must be a power of two");
      assert (DIV_W >= 1 && DIV_W <= 24)
         else $error("DIV_W out of range");
   end

   logic             tick;
   logic             run;
   logic             clr;
   logic             pre_q;
   logic [DIV_W-1:0] div_q;
   logic [7:0]       data_q;
   tx_fmt_t          fmt_q;
   logic             par_bit;
   logic             par_on;

   uart_tx_tick #(.PRE_DIV(PRE_DIV), .DIV_W(DIV_W)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .run    (run),
      .pre_en (pre_q),
      .div    (div_q),
      .tick   (tick)
   );

   uart_tx_parity u_par (
      .data    (data_q),
      .len     (fmt_q.len),
      .mode    (fmt_q.par),
      .par_bit (par_bit),
      .par_on  (par_on)
   );

   uart_tx_seq #(.OVERSAMPLE(OVERSAMPLE), .DIV_W(DIV_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .in_valid (in_valid),
      .in_data  (in_data),
      .cfg_len  (cfg_len),
      .cfg_par  (cfg_par),
      .cfg_stop (cfg_stop),
      .cfg_pre8 (cfg_pre8),
      .baud_div (baud_div),
      .par_bit  (par_bit),
      .par_on   (par_on),
      .in_ready (in_ready),
      .tx_line  (tx_line),
      .run      (run),
      .clr      (clr),
      .pre_q    (pre_q),
      .div_q    (div_q),
      .data_q   (data_q),
      .fmt_q    (fmt_q)
   );

endmodule

// File: tb/sim_uart_frame_tx.sv
`timescale 1ns/1ps
module sim_uart_frame_tx;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [7:0]  in_data = '0;
   logic [1:0]  cfg_len = '0;
   logic [2:0]  cfg_par = '0;
   logic [1:0]  cfg_stop = '0;
   logic        cfg_pre8 = 1'b0;
   logic [11:0] baud_div = '0;
   logic        tx_line;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   uart_frame_tx u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .cfg_len(cfg_len), .cfg_par(cfg_par),
      .cfg_stop(cfg_stop), .cfg_pre8(cfg_pre8), .baud_div(baud_div),
      .tx_line(tx_line)
   );

   // ---------------- reference model: one queue entry per tick ----------------
   bit    lvl_q[$];
   string tag_q[$];
   bit    m_busy = 0;
   int    m_sub = 0;
   int    m_span = 1;
   string tag_force = "";

   function automatic int n_bits(input logic [1:0] l);
      return (l == 2'b11) ? 6 : (l == 2'b10) ? 7 : 8;
   endfunction

   function automatic int stop_ticks(input logic [1:0] s);
      return (s == 2'b01) ? 24 : (s == 2'b10) ? 32 : 16;
   endfunction

   task automatic push_bit(input bit v, input int n, input string t);
      for (int i = 0; i < n; i++) begin
         lvl_q.push_back(v);
         tag_q.push_back(tag_force != "" ? tag_force : t);
      end
   endtask

   task automatic build_frame();
      int nb;
      bit ones;
      nb = n_bits(cfg_len);
      ones = 0;
      m_span = (int'(baud_div) + 1) * (cfg_pre8 ? 8 : 1);
      push_bit(1'b0, 16, "R3");
      for (int i = 0; i < nb; i++) begin
         push_bit(in_data[i], 16, "R4");
         ones ^= in_data[i];
      end
      case (cfg_par)
         3'b000: push_bit(ones, 16, "R5");
         3'b001: push_bit(~ones, 16, "R5");
         3'b010: push_bit(1'b0, 16, "R6");
         3'b011: push_bit(1'b1, 16, "R6");
         default: ;
      endcase
      push_bit(1'b1, stop_ticks(cfg_stop), "R7");
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0;
         m_sub  = 0;
         lvl_q.delete();
         tag_q.delete();
      end else if (!m_busy) begin
         if (in_valid) begin
            build_frame();
            m_busy = 1;
            m_sub  = 0;
         end
      end else begin
         m_sub++;
         if (m_sub == m_span) begin
            m_sub = 0;
            void'(lvl_q.pop_front());
            void'(tag_q.pop_front());
            if (lvl_q.size() == 0) m_busy = 0;
         end
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit    el;
         string et;
         el = m_busy ? lvl_q[0] : 1'b1;
         et = m_busy ? tag_q[0] : (tag_force != "" ? tag_force : "R10");
         check(tx_line === el, et, "tx_line", int'(tx_line), int'(el));
         check(in_ready === !m_busy, "R2", "in_ready", int'(in_ready), int'(!m_busy));
      end
   end

   // ---------------- stimulus ----------------
   task automatic send(input logic [7:0] d, input logic [1:0] l, input logic [2:0] p,
                       input logic [1:0] s, input logic pr, input logic [11:0] dv,
                       input bit scramble, input bit wait_end);
      int n;
      int exp_n;
      while (!in_ready) @(negedge clk);
      in_data = d; cfg_len = l; cfg_par = p; cfg_stop = s;
      cfg_pre8 = pr; baud_div = dv; in_valid = 1'b1;
      exp_n = (16 * (1 + n_bits(l) + (p[2] ? 0 : 1)) + stop_ticks(s))
              * ((int'(dv) + 1) * (pr ? 8 : 1));
      @(negedge clk);
      in_valid = 1'b0;
      if (scramble) begin
         in_data = ~d; cfg_len = ~l; cfg_par = ~p; cfg_stop = ~s;
         cfg_pre8 = ~pr; baud_div = dv + 12'd3;
      end
      if (wait_end) begin
         n = 0;
         while (!in_ready) begin
            n++;
            @(negedge clk);
         end
         check(n == exp_n, scramble ? "R9" : "R8", "busy clocks", n, exp_n);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(tx_line === 1'b1, "R1", "tx_line after reset", int'(tx_line), 1);
      check(in_ready === 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(tx_line === 1'b1, "R1", "tx_line after release", int'(tx_line), 1);

      send(8'h55, 2'b00, 3'b100, 2'b00, 1'b0, 12'd0, 0, 1);  // R3 R4 no parity
      send(8'hA3, 2'b11, 3'b000, 2'b01, 1'b0, 12'd1, 0, 1);  // R4 6 bits, R5 even, R7 1.5
      send(8'hC5, 2'b10, 3'b001, 2'b10, 1'b0, 12'd0, 0, 1);  // R4 7 bits, R5 odd, R7 2
      send(8'h0F, 2'b01, 3'b010, 2'b00, 1'b0, 12'd2, 0, 1);  // R6 space
      send(8'hF0, 2'b00, 3'b011, 2'b11, 1'b0, 12'd0, 0, 1);  // R6 mark, R7 reserved
      send(8'hFF, 2'b11, 3'b000, 2'b10, 1'b1, 12'd0, 0, 1);  // R8 prescaler, R4 upper bits
      send(8'h6B, 2'b00, 3'b111, 2'b01, 1'b0, 12'd1, 0, 1);  // R6 1xx no parity
      tag_force = "R9";
      send(8'h3C, 2'b00, 3'b001, 2'b01, 1'b1, 12'd1, 1, 1);  // R9 format held
      tag_force = "";
      repeat (5) @(negedge clk);                             // R10 idle gap
      send(8'h81, 2'b00, 3'b000, 2'b00, 1'b0, 12'd0, 0, 0);  // R2 back to back
      send(8'h7E, 2'b10, 3'b001, 2'b00, 1'b0, 12'd0, 0, 1);
      repeat (20) @(negedge clk);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL R2 watchdog actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule